// File: doc/BRIEF.md
# Option Byte Loader with Complement Check

This block brings a set of configuration bytes out of non-volatile storage after every reset. Storage holds each byte as a 16-bit word: the value in the low byte and its bitwise complement in the high byte. Coming out of reset, the loader walks the words in ascending address order through a simple synchronous read port with a fixed latency. It compares each value against its complement, latches values that pass, and raises an error flag for each word that fails.

A failing word does not pass its raw value on. The loader substitutes a safe byte for that entry. Entry 0 and entries 4 and up take 0x00, which leaves the protections they control switched on. Entries 1 to 3 take 0xFF. Entries 2 and 3 feed no protection logic; they are loaded and checked like the others, so software can keep integrity-checked data there. Until loading is finished, the byte outputs show the safe values and the error flags read zero. Once done is raised, the outputs are frozen: changes to storage while running reach them only through the next reset.

Top module: `optbyte_loader`

## Requirements
- R1: After reset the block issues exactly one single-cycle read request per entry, for entries 0 to 7 in ascending order, at address BASE_ADDR + 2*entry. Consecutive requests therefore differ by 2 in address.
- R2: The block uses the storage data that appears READ_LAT cycles after the cycle in which the request was asserted (READ_LAT = 2 by default).
- R3: A word passes when bits [15:8] equal the bitwise inverse of bits [7:0]. A passing entry drives its bits [7:0] on opt_bytes[8*i+7:8*i] and leaves opt_err[i] at 0.
- R4: A word that fails sets opt_err[i] to 1 and drives a safe byte for that entry: 0x00 for entries 0 and 4 to 7, 0xFF for entries 1 to 3.
- R5: With the first rising edge after reset release counted as edge 1, done becomes 1 after edge N*(READ_LAT+1)+2 (edge 26 by default). This is one cycle after the last compare. Once set, done stays at 1 until reset.
- R6: While done is 0, including during reset, opt_bytes holds the safe bytes of R4 and opt_err is all zero.
- R7: Once done is 1, the block issues no further read requests, and opt_bytes and opt_err do not change even when storage contents change.
- R8: Asserting and releasing reset reloads every entry from the current storage contents.
- R9: Entries 2 and 3 are checked and flagged exactly like the other entries.
- R10: All-erased storage (every word 0xFFFF) fails the check on every entry, giving opt_err = 0xFF and all safe bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts a load |
| rd_req | output | 1 | Read request to storage, one cycle per entry |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_data | input | 16 | Storage word, valid READ_LAT cycles after the request |
| done | output | 1 | All entries loaded and checked |
| opt_err | output | N | Per-entry complement mismatch flag |
| opt_bytes | output | 8*N | Latched bytes, entry i at bits [8*i+7:8*i] |

## Verification
Each entry takes READ_LAT+1 cycles: one request cycle, then the compare at the end of the cycle in which the data is valid. The bench counts rising edges from reset release and expects done after exactly edge 26, holding the safe outputs on every cycle before that. The storage model in the bench answers requests after exactly READ_LAT cycles, so only a loader that samples at the right cycle latches the expected words. All outputs are sampled on the falling edge, after the rising edge at which they are due. The freeze check leaves twenty cycles after a storage change before comparing.

// File: rtl/optbyte_loader.sv
module optbyte_loader #(
  parameter int                 N         = 8,
  parameter int                 ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 32'h0000_0800,
  parameter int                 READ_LAT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [15:0]       rd_data,
  output logic              done,
  output logic [N-1:0]      opt_err,
  output logic [8*N-1:0]    opt_bytes
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int CNT_W = $clog2(READ_LAT + 1);
  localparam int RC_W  = $clog2(N + 1);

  function automatic logic [8*N-1:0] safe_vec();
    logic [8*N-1:0] v;
    for (int i = 0; i < N; i++)
      v[8*i +: 8] = (i >= 1 && i <= 3) ? 8'hFF : 8'h00;
    return v;
  endfunction

  localparam logic [8*N-1:0] SAFE_VEC = safe_vec();

  typedef enum logic [2:0] {S_START, S_REQ, S_WAIT, S_SETTLE, S_READY} state_t;

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [8*N-1:0]   val_q;
  logic [N-1:0]     err_q;

  wire pair_ok  = (rd_data[15:8] == ~rd_data[7:0]);
  wire cmp_now  = (state == S_WAIT) && (cnt == CNT_W'(READ_LAT));
  wire last_idx = (idx == IDX_W'(N - 1));

  assign rd_req    = (state == S_REQ);
  assign rd_addr   = BASE_ADDR + ADDR_W'({idx, 1'b0});
  assign done      = (state == S_READY);
  assign opt_bytes = done ? val_q : SAFE_VEC;
  assign opt_err   = done ? err_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_START;
      idx   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_START: state <= S_REQ;
        S_REQ: begin
          cnt   <= CNT_W'(1);
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (cmp_now) begin
            if (last_idx) state <= S_SETTLE;
            else begin
              idx   <= idx + 1'b1;
              state <= S_REQ;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SETTLE: state <= S_READY;
        default:  state <= S_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= SAFE_VEC;
      err_q <= '0;
    end else if (cmp_now) begin
      val_q[8*idx +: 8] <= pair_ok ? rd_data[7:0] : SAFE_VEC[8*idx +: 8];
      err_q[idx]        <= ~pair_ok;
    end
  end

  logic [ADDR_W-1:0] prev_addr;
  logic              seen_req;
  logic [RC_W-1:0]   req_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      seen_req  <= 1'b0;
      req_cnt   <= '0;
    end else if (rd_req) begin
      prev_addr <= rd_addr;
      seen_req  <= 1'b1;
      req_cnt   <= req_cnt + 1'b1;
    end
  end

  // R1: ascending addresses in steps of one 16-bit word
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && seen_req) |-> (rd_addr == prev_addr + ADDR_W'(2)));

  // R1: each request lasts a single cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R1: exactly N requests by the time loading is finished
  a_r1_req_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_cnt == RC_W'(N)));

  // R5: done is sticky until reset
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R7: no storage traffic after loading
  a_r7_no_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

  // R7: outputs frozen while running
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(opt_bytes) && $stable(opt_err)));

endmodule

// File: tb/test_optbyte_loader.sv
module test_optbyte_loader;
  localparam int N        = 8;
  localparam int ADDR_W   = 32;
  localparam logic [31:0] BASE = 32'h0000_0800;
  localparam int LAT      = 2;
  localparam int EXP_DONE = N * (LAT + 1) + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic [15:0]       rd_data;
  logic              done;
  logic [N-1:0]      opt_err;
  logic [8*N-1:0]    opt_bytes;

  int checks = 0;
  int fails  = 0;

  logic [15:0] mem [N];
  logic [15:0] pipe [LAT];
  int          req_log [16];
  int          req_num = 0;

  always #10 clk = ~clk;

  optbyte_loader #(.N(N), .ADDR_W(ADDR_W), .BASE_ADDR(BASE), .READ_LAT(LAT)) i_optbyte_loader (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .opt_err(opt_err), .opt_bytes(opt_bytes));

  assign rd_data = pipe[LAT-1];

  always @(posedge clk) begin
    for (int k = LAT - 1; k > 0; k--) pipe[k] <= pipe[k-1];
    pipe[0] <= 16'h0000;
    if (rd_req) begin
      int e;
      e = int'((rd_addr - BASE) >> 1);
      if (req_num < 16) req_log[req_num] <= int'(rd_addr);
      req_num <= req_num + 1;
      pipe[0] <= (e >= 0 && e < N) ? mem[e] : 16'hDEAD;
    end
  end

  function automatic logic [8*N-1:0] safe_ref();
    logic [8*N-1:0] v;
    for (int i = 0; i < N; i++) v[8*i +: 8] = (i == 1 || i == 2 || i == 3) ? 8'hFF : 8'h00;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_pair(input int e, input logic [7:0] v);
    mem[e] = {~v, v};
  endtask

  task automatic start_load();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    req_num = 0;
    rst_n = 1'b1;
  endtask

  task automatic finish_load(input string req);
    int  edge_at = 0;
    bit  safe_ok = 1'b1;
    for (int e = 1; e <= EXP_DONE + 10; e++) begin
      @(posedge clk); @(negedge clk);
      if (done) begin edge_at = e; break; end
      if (opt_bytes !== safe_ref() || opt_err !== '0) safe_ok = 1'b0;
    end
    chk(edge_at == EXP_DONE, req, "done edge", 64'(edge_at), 64'(EXP_DONE));
    chk(safe_ok, "R6", "safe outputs before done", 64'(safe_ok), 64'd1);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R6", "done in reset", 64'(done), 64'd0);
    chk(opt_bytes === safe_ref(), "R6", "bytes in reset", opt_bytes, safe_ref());
    chk(opt_err === '0, "R6", "err in reset", 64'(opt_err), 64'd0);
    chk(rd_req === 1'b0, "R6", "no request in reset", 64'(rd_req), 64'd0);
  endtask

  task automatic t_erased();
    for (int e = 0; e < N; e++) mem[e] = 16'hFFFF;
    start_load();
    finish_load("R5");
    chk(opt_err === 8'hFF, "R10", "erased err", 64'(opt_err), 64'hFF);
    chk(opt_bytes === safe_ref(), "R10", "erased bytes", opt_bytes, safe_ref());
  endtask

  task automatic t_order();
    bit ok = 1'b1;
    chk(req_num == N, "R1", "request count", 64'(req_num), 64'(N));
    for (int k = 0; k < N; k++)
      if (req_log[k] != int'(BASE) + 2 * k) ok = 1'b0;
    chk(ok, "R1", "ascending addresses", 64'(req_log[N-1]), 64'(int'(BASE) + 2 * (N - 1)));
  endtask

  task automatic t_valid(input logic [8*N-1:0] vals);
    for (int e = 0; e < N; e++) set_pair(e, vals[8*e +: 8]);
    start_load();
    finish_load("R5");
    chk(opt_bytes === vals, "R2", "valid bytes at latency", opt_bytes, vals);
    chk(opt_err === '0, "R3", "valid err", 64'(opt_err), 64'd0);
  endtask

  task automatic t_corrupt_each();
    logic [8*N-1:0] vals = 64'h3C_96_81_7E_42_24_A5_5A;
    for (int k = 0; k < N; k++) begin
      logic [8*N-1:0] expv;
      for (int e = 0; e < N; e++) set_pair(e, vals[8*e +: 8]);
      mem[k][8 + (k % 8)] = ~mem[k][8 + (k % 8)];
      expv = vals;
      expv[8*k +: 8] = safe_ref() >> (8 * k);
      start_load();
      finish_load("R5");
      chk(opt_err === N'(1 << k), (k == 2 || k == 3) ? "R9" : "R4", "corrupt err",
          64'(opt_err), 64'(1 << k));
      chk(opt_bytes === expv, (k == 2 || k == 3) ? "R9" : "R4", "corrupt bytes", opt_bytes, expv);
    end
  endtask

  task automatic t_frozen_then_reload();
    logic [8*N-1:0] a = 64'h11_22_33_44_55_66_77_88;
    logic [8*N-1:0] b = 64'hF0_0F_C3_3C_E1_1E_D2_2D;
    int req_before;
    for (int e = 0; e < N; e++) set_pair(e, a[8*e +: 8]);
    start_load();
    finish_load("R5");
    req_before = req_num;
    for (int e = 0; e < N; e++) set_pair(e, b[8*e +: 8]);
    mem[0] = 16'h1234;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(done === 1'b1, "R5", "done sticky", 64'(done), 64'd1);
    chk(opt_bytes === a, "R7", "bytes frozen", opt_bytes, a);
    chk(opt_err === '0, "R7", "err frozen", 64'(opt_err), 64'd0);
    chk(req_num == req_before, "R7", "no requests after done", 64'(req_num), 64'(req_before));
    set_pair(0, b[7:0]);
    start_load();
    finish_load("R5");
    chk(opt_bytes === b, "R8", "reload bytes", opt_bytes, b);
    chk(opt_err === '0, "R8", "reload err", 64'(opt_err), 64'd0);
  endtask

  initial begin
    for (int k = 0; k < LAT; k++) pipe[k] = 16'h0000;
    t_reset_state();
    t_erased();
    t_order();
    t_valid(64'hFF_FF_FF_FF_00_00_FF_A5);
    t_valid(64'h3C_96_81_7E_42_24_A5_5A);
    t_order();
    t_corrupt_each();
    t_frozen_then_reload();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule